// File: doc/BRIEF.md
# Hot-swap two-wire bus connect controller

This controller sits between a backplane two-wire bus (data and clock lines) and the matching bus on a plug-in card. On live insertion it holds the two sides apart. Once both supply-good flags are up and the enable input is high, it waits for the backplane to reach a safe point: a STOP condition, or both backplane lines held high for a programmable number of cycles. It then checks that both card lines are high, and only then joins the two sides.

While joined, each line behaves as one wired-AND net spanning both sides. A low driven by any device on either side is copied to the other side through an open-drain pull-down request. The line rises only when every device on both sides has let go. Each line records which side pulled it low first, so the controller never keeps a line low through its own pull-down.

Dropping the enable input, or losing either supply flag, separates the sides within three clock edges. Raising the enable again restarts the full wait. All line, supply and enable inputs pass through a two-stage synchronizer. Every output is registered.

Top module: `hsb_connect_ctrl`

## Requirements
- R1: While either supply-good flag is low, the controller stays disconnected. `linked_o` is 0, all four pull-down outputs are 0, and activity on the backplane lines is not passed to the card side.
- R2: In the waiting state, a STOP connects the sides on the third clock edge after the change, provided both card lines are high. A STOP is a rise of backplane data while backplane clock is high. Line inputs read 1 for high.
- R3: The idle condition is IDLE_CYCLES consecutive waiting cycles with both backplane lines high. It connects on the IDLE_CYCLES-th such cycle and not before. After leaving lockout or disable with idle lines, connection occurs on edge 3+IDLE_CYCLES.
- R4: No connection is made while either card line is low. The STOP or idle condition only counts when both card lines read high. The idle condition stays in effect while the backplane remains high, so releasing the card lines then connects on the third edge.
- R5: `boost_en_o` equals `linked_o` at all times.
- R6: Enable low clears `linked_o` and `boost_en_o` on the third clock edge after the change. From then on, backplane activity no longer reaches the card side.
- R7: After enable or supply returns, no connection is made until a fresh STOP or idle condition is seen in the waiting state.
- R8: Any low on a backplane line during waiting restarts the idle count from zero.
- R9: While connected, each line follows wired-AND across both sides. A pull-down output of 1 requests a low. A low on either side pulls the other side low, and a line goes high on both sides once no device on either side holds it low. This holds independently for data and clock.
- R10: While connected, only the side opposite the first-low side is driven. That drive is released on the third edge after the originating side goes high. The two pull-downs of one line are never active together.
- R11: Loss of the card supply flag while connected disconnects on the third clock edge.
- R12: After synchronous reset the controller is disconnected, with `linked_o`, `boost_en_o` and all pull-down outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bp_sda_i | input | 1 | Backplane data line level (1 = high) |
| bp_scl_i | input | 1 | Backplane clock line level |
| cd_sda_i | input | 1 | Card data line level |
| cd_scl_i | input | 1 | Card clock line level |
| bp_pwr_ok_i | input | 1 | Backplane supply good |
| cd_pwr_ok_i | input | 1 | Card supply good |
| en_i | input | 1 | Connection enable |
| bp_sda_pd_o | output | 1 | Pull backplane data low |
| bp_scl_pd_o | output | 1 | Pull backplane clock low |
| cd_sda_pd_o | output | 1 | Pull card data low |
| cd_scl_pd_o | output | 1 | Pull card clock low |
| linked_o | output | 1 | Sides are joined |
| boost_en_o | output | 1 | Rise-time accelerator enable |

## Verification
The bench models each line as a wired-AND of the bench's device pull-downs and the controller's own pull-down outputs. It then drives directed sequences: a STOP against an idle timeout, an idle run broken by a brief clock-low pulse, and a STOP arriving while a card line is still held low. Randomized device pulls on all four lines, while connected, tell a correct two-sided wired-AND apart from a bridge that latches itself low or forgets a second holder. Exact-edge checks on enable and supply removal separate the fast three-edge drop from a slower or missing one.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [1:0] {
        ST_LOCKOUT   = 2'd0,
        ST_WAIT_IDLE = 2'd1,
        ST_CONNECTED = 2'd2,
        ST_DISABLED  = 2'd3
    } link_state_e;

    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_BP     = 2'd1,
        LD_CD     = 2'd2,
        LD_SETTLE = 2'd3
    } lead_e;

endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
    parameter int                WIDTH   = 7,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsb_idle_watch.sv
module hsb_idle_watch #(
    parameter int IDLE_CYCLES = 9500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic stop_o,
    output logic idle_o
);

    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic          sda_prev;
        logic          scl_prev;
        logic [CW-1:0] cnt;
    } watch_t;

    watch_t w_d, w_q;
    logic   both_high;

    assign both_high = sda_i & scl_i;
    assign stop_o    = sda_i & ~w_q.sda_prev & scl_i & w_q.scl_prev;
    assign idle_o    = both_high & (w_q.cnt == LIMIT);

    always_comb begin
        w_d          = w_q;
        w_d.sda_prev = sda_i;
        w_d.scl_prev = scl_i;
        if (!run_i || !both_high) begin
            w_d.cnt = '0;
        end else if (w_q.cnt != LIMIT) begin
            w_d.cnt = w_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            w_q <= '{sda_prev: 1'b1, scl_prev: 1'b1, cnt: '0};
        end else begin
            w_q <= w_d;
        end
    end

    AST_IDLE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_q.cnt <= LIMIT); // R3

    AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !both_high) |=> (w_q.cnt == '0) && !idle_o); // R8

endmodule

// File: rtl/hsb_line_bridge.sv
module hsb_line_bridge
    import hsb_pkg::*;
#(
    parameter int SETTLE = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic bp_i,
    input  logic cd_i,
    output logic drive_bp_o,
    output logic drive_cd_o
);

    localparam int SW = $clog2(SETTLE + 1);

    typedef struct packed {
        lead_e         lead;
        logic [SW-1:0] wait_cnt;
    } bridge_t;

    bridge_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (!active_i) begin
            b_d.lead     = LD_NONE;
            b_d.wait_cnt = '0;
        end else begin
            unique case (b_q.lead)
                LD_NONE: begin
                    if (!bp_i)      b_d.lead = LD_BP;
                    else if (!cd_i) b_d.lead = LD_CD;
                end
                LD_BP: begin
                    if (bp_i) begin
                        b_d.lead     = LD_SETTLE;
                        b_d.wait_cnt = '0;
                    end
                end
                LD_CD: begin
                    if (cd_i) begin
                        b_d.lead     = LD_SETTLE;
                        b_d.wait_cnt = '0;
                    end
                end
                LD_SETTLE: begin
                    if (b_q.wait_cnt == SW'(SETTLE)) begin
                        if (!bp_i)      b_d.lead = LD_BP;
                        else if (!cd_i) b_d.lead = LD_CD;
                        else            b_d.lead = LD_NONE;
                    end else begin
                        b_d.wait_cnt = b_q.wait_cnt + SW'(1);
                    end
                end
                default: b_d.lead = LD_NONE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            b_q <= '{lead: LD_NONE, wait_cnt: '0};
        end else begin
            b_q <= b_d;
        end
    end

    assign drive_cd_o = (b_q.lead == LD_BP);
    assign drive_bp_o = (b_q.lead == LD_CD);

    AST_BP_LEAD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && b_q.lead == LD_BP && bp_i) |=> !drive_cd_o); // R10

    AST_CD_LEAD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && b_q.lead == LD_CD && cd_i) |=> !drive_bp_o); // R10

    AST_IDLE_WHEN_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_i |=> !drive_bp_o && !drive_cd_o); // R9

endmodule

// File: rtl/hsb_connect_ctrl.sv
module hsb_connect_ctrl
    import hsb_pkg::*;
#(
    parameter int IDLE_CYCLES = 9500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    input  logic bp_pwr_ok_i,
    input  logic cd_pwr_ok_i,
    input  logic en_i,
    output logic bp_sda_pd_o,
    output logic bp_scl_pd_o,
    output logic cd_sda_pd_o,
    output logic cd_scl_pd_o,
    output logic linked_o,
    output logic boost_en_o
);

    localparam int NLINES = 2;
    localparam int NSYNC  = 7;

    typedef struct packed {
        link_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [NSYNC-1:0] raw, synced;
    logic bp_sda_s, bp_scl_s, cd_sda_s, cd_scl_s, bp_ok_s, cd_ok_s, en_s;
    logic stop_seen, idle_seen, waiting, joined;
    logic [NLINES-1:0] line_bp, line_cd, drv_bp, drv_cd;

    assign raw = {en_i, cd_pwr_ok_i, bp_pwr_ok_i, cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};

    hsb_sync #(
        .WIDTH   (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (7'b000_1111)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (raw),
        .q_o    (synced)
    );

    assign {en_s, cd_ok_s, bp_ok_s, cd_scl_s, cd_sda_s, bp_scl_s, bp_sda_s} = synced;

    assign waiting = (fsm_q.st == ST_WAIT_IDLE);
    assign joined  = (fsm_q.st == ST_CONNECTED);

    hsb_idle_watch #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_idle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (waiting),
        .sda_i  (bp_sda_s),
        .scl_i  (bp_scl_s),
        .stop_o (stop_seen),
        .idle_o (idle_seen)
    );

    assign line_bp = {bp_scl_s, bp_sda_s};
    assign line_cd = {cd_scl_s, cd_sda_s};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        hsb_line_bridge #(
            .SETTLE (SYNC_STAGES)
        ) u_bridge (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .active_i   (joined),
            .bp_i       (line_bp[g]),
            .cd_i       (line_cd[g]),
            .drive_bp_o (drv_bp[g]),
            .drive_cd_o (drv_cd[g])
        );
    end

    always_comb begin
        fsm_d = fsm_q;
        if (!(bp_ok_s && cd_ok_s)) begin
            fsm_d.st = ST_LOCKOUT;
        end else begin
            unique case (fsm_q.st)
                ST_LOCKOUT:   fsm_d.st = en_s ? ST_WAIT_IDLE : ST_DISABLED;
                ST_DISABLED:  if (en_s) fsm_d.st = ST_WAIT_IDLE;
                ST_WAIT_IDLE: begin
                    if (!en_s) begin
                        fsm_d.st = ST_DISABLED;
                    end else if ((stop_seen || idle_seen) && cd_sda_s && cd_scl_s) begin
                        fsm_d.st = ST_CONNECTED;
                    end
                end
                ST_CONNECTED: if (!en_s) fsm_d.st = ST_DISABLED;
                default:      fsm_d.st = ST_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fsm_q <= '{st: ST_LOCKOUT};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign linked_o    = joined;
    assign boost_en_o  = joined;
    assign bp_sda_pd_o = drv_bp[0] & joined;
    assign bp_scl_pd_o = drv_bp[1] & joined;
    assign cd_sda_pd_o = drv_cd[0] & joined;
    assign cd_scl_pd_o = drv_cd[1] & joined;

    AST_LOCKOUT_ISOLATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bp_ok_s && cd_ok_s) |=> !linked_o); // R1

    AST_CD_SUPPLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (linked_o && !cd_ok_s) |=> !linked_o); // R11

    AST_EN_LOW_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_s |=> !linked_o && !boost_en_o); // R6

    AST_LINK_NEEDS_CARD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(linked_o) |-> $past(cd_sda_s && cd_scl_s)); // R4

    AST_LINK_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(linked_o) |-> $past(stop_seen || idle_seen)); // R2

    AST_LINK_FROM_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(linked_o) |-> $past(waiting)); // R7

    AST_ONE_SIDE_PER_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bp_sda_pd_o && cd_sda_pd_o) && !(bp_scl_pd_o && cd_scl_pd_o)); // R10

endmodule

// File: tb/hsb_connect_ctrl_tb.sv
module hsb_connect_ctrl_tb_top;

    localparam int IDLE = 40;

    logic clk = 1'b0;
    logic rst_n;
    logic dev_bp_sda, dev_bp_scl, dev_cd_sda, dev_cd_scl;
    logic bp_ok, cd_ok, en;
    logic bp_sda_pd, bp_scl_pd, cd_sda_pd, cd_scl_pd, linked, boost;
    wire  bp_sda = !(dev_bp_sda | bp_sda_pd);
    wire  bp_scl = !(dev_bp_scl | bp_scl_pd);
    wire  cd_sda = !(dev_cd_sda | cd_sda_pd);
    wire  cd_scl = !(dev_cd_scl | cd_scl_pd);

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hsb_connect_ctrl #(.IDLE_CYCLES(IDLE), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
        .bp_pwr_ok_i(bp_ok), .cd_pwr_ok_i(cd_ok), .en_i(en),
        .bp_sda_pd_o(bp_sda_pd), .bp_scl_pd_o(bp_scl_pd),
        .cd_sda_pd_o(cd_sda_pd), .cd_scl_pd_o(cd_scl_pd),
        .linked_o(linked), .boost_en_o(boost)
    );

    function automatic logic wired_and(input logic pull_a, input logic pull_b);
        return !(pull_a | pull_b);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4417));
        rst_n = 1'b0; en = 1'b0; bp_ok = 1'b0; cd_ok = 1'b0;
        dev_bp_sda = 1'b0; dev_bp_scl = 1'b0; dev_cd_sda = 1'b0; dev_cd_scl = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R12", "linked", linked, 1'b0);
        check("R12", "boost", boost, 1'b0);
        check("R12", "pulldowns", bp_sda_pd | bp_scl_pd | cd_sda_pd | cd_scl_pd, 1'b0);

        // R1: lockout while card supply is absent
        bp_ok = 1'b1; en = 1'b1;
        tick(IDLE + 10);
        check("R1", "linked in lockout", linked, 1'b0);
        dev_bp_sda = 1'b1;
        tick(6);
        check("R1", "card sda isolated", cd_sda, 1'b1);
        check("R1", "no pulldown", bp_sda_pd | cd_sda_pd, 1'b0);
        dev_bp_sda = 1'b0;
        tick(2);

        // R3: idle timeout, exact edge
        cd_ok = 1'b1;
        tick(IDLE + 2);
        check("R3", "linked one edge early", linked, 1'b0);
        tick(1);
        check("R3", "linked at timeout", linked, 1'b1);
        check("R5", "boost with link", boost, linked);

        // R9/R10 directed
        dev_bp_sda = 1'b1;
        tick(3);
        check("R9", "card sda follows", cd_sda, 1'b0);
        check("R10", "origin side undriven", bp_sda_pd, 1'b0);
        dev_bp_sda = 1'b0;
        tick(3);
        check("R10", "release on third edge", cd_sda, 1'b1);
        tick(6);
        dev_cd_scl = 1'b1;
        tick(3);
        check("R9", "bp scl follows card", bp_scl, 1'b0);
        dev_bp_scl = 1'b1;
        tick(8);
        dev_cd_scl = 1'b0;
        tick(10);
        check("R9", "bp holder keeps card scl low", cd_scl, 1'b0);
        check("R9", "bp scl low", bp_scl, 1'b0);
        dev_bp_scl = 1'b0;
        tick(10);
        check("R9", "scl high both sides", bp_scl & cd_scl, 1'b1);

        // R9 random
        for (int i = 0; i < 200; i++) begin
            dev_bp_sda = 1'($urandom);
            dev_bp_scl = 1'($urandom);
            dev_cd_sda = 1'($urandom);
            dev_cd_scl = 1'($urandom);
            tick(12);
            check("R9", "bp sda", bp_sda, wired_and(dev_bp_sda, dev_cd_sda));
            check("R9", "cd sda", cd_sda, wired_and(dev_bp_sda, dev_cd_sda));
            check("R9", "bp scl", bp_scl, wired_and(dev_bp_scl, dev_cd_scl));
            check("R9", "cd scl", cd_scl, wired_and(dev_bp_scl, dev_cd_scl));
            check("R10", "one side driven",
                  (bp_sda_pd & cd_sda_pd) | (bp_scl_pd & cd_scl_pd), 1'b0);
        end
        dev_bp_sda = 1'b0; dev_bp_scl = 1'b0; dev_cd_sda = 1'b0; dev_cd_scl = 1'b0;
        tick(12);
        check("R9", "still linked", linked, 1'b1);

        // R6: enable off timing
        en = 1'b0;
        tick(2);
        check("R6", "linked before third edge", linked, 1'b1);
        tick(1);
        check("R6", "dropped on third edge", linked, 1'b0);
        check("R5", "boost dropped", boost, 1'b0);
        dev_bp_sda = 1'b1;
        tick(6);
        check("R6", "card sda isolated", cd_sda, 1'b1);

        // R7 and R2: re-enable waits, STOP connects
        en = 1'b1;
        tick(20);
        check("R7", "no immediate reconnect", linked, 1'b0);
        dev_bp_sda = 1'b0;
        tick(2);
        check("R2", "not before third edge", linked, 1'b0);
        tick(1);
        check("R2", "stop connects", linked, 1'b1);

        // R4: card line held low blocks STOP and idle
        en = 1'b0;
        tick(5);
        dev_cd_scl = 1'b1;
        dev_bp_sda = 1'b1;
        tick(4);
        en = 1'b1;
        tick(5);
        dev_bp_sda = 1'b0;
        tick(6);
        check("R4", "stop with card low", linked, 1'b0);
        tick(IDLE + 5);
        check("R4", "idle with card low", linked, 1'b0);
        dev_cd_scl = 1'b0;
        tick(3);
        check("R4", "connect when card released", linked, 1'b1);

        // R8: activity restarts idle count
        en = 1'b0;
        tick(5);
        en = 1'b1;
        tick(3 + IDLE - 10);
        dev_bp_scl = 1'b1;
        tick(1);
        dev_bp_scl = 1'b0;
        tick(IDLE - 5);
        check("R8", "count restarted", linked, 1'b0);
        tick(20);
        check("R8", "connect after full restart", linked, 1'b1);

        // R11: card supply loss
        cd_ok = 1'b0;
        tick(3);
        check("R11", "disconnect on supply loss", linked, 1'b0);
        check("R11", "boost off", boost, 1'b0);
        dev_bp_sda = 1'b1;
        tick(6);
        check("R11", "card sda isolated", cd_sda, 1'b1);
        dev_bp_sda = 1'b0;
        cd_ok = 1'b1;
        tick(6);
        check("R7", "no reconnect after supply return", linked, 1'b0);
        tick(IDLE + 5);
        check("R3", "reconnect after idle", linked, 1'b1);

        // R1: backplane supply loss
        bp_ok = 1'b0;
        tick(3);
        check("R1", "disconnect on bp supply loss", linked, 1'b0);

        finish_run();
    end

endmodule